// File: doc/BRIEF.md
# Memory Exception Cause Detector

This unit classifies the completion of one instruction fetch and one data access per cycle for a 32-bit RISC-V style core. It decides whether either access traps, and if so which cause code and trap value the trap logic should record. The fetch side sees the fetch address, its port (peripheral bus or local memory) and that port's read response or ECC flags. The data side sees address, size, direction, exclusive and atomic attributes, the target port (peripheral bus, cache bus, local memory), the AXI4 read or write response, local-memory ECC flags and a one-bit protection-check failure.

The decision is made combinationally and registered, so the trap is reported one cycle after the access is presented. When both sides fault in the same cycle, the data access wins because it belongs to the older instruction. Page-table walking, protection evaluation and pipeline flushing are done elsewhere.

Top module: `mem_exc_detect`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it, exc_valid_o, exc_cause_o and exc_tval_o are zero. In any cycle with no exception, all three are zero.
- R2: With COMPRESSED=0, a fetch whose address bit 1 is set reports cause 0 (fetch misaligned). With COMPRESSED=1, cause 0 is never reported.
- R3: An aligned fetch from the peripheral port (if_local_i=0) with a response of 2 or 3 (error) reports cause 1. A fetch from local memory (if_local_i=1) with an uncorrectable ECC flag reports cause 1. Response 0 (OKAY) does not cause an exception.
- R4: d_size_i encodes 0 byte, 1 half, 2 or 3 word. A word access with address bits [1:0] nonzero, or a half access with bit 0 set, is misaligned. A misaligned access reports cause 6 if d_write_i or d_amo_i is set, and cause 4 otherwise. Byte accesses are never misaligned.
- R5: On the data peripheral port (d_tgt_i=0), a load reports cause 5 on read response 2 or 3. It also reports cause 5 on response 0 (OKAY) when d_excl_i or d_amo_i is set. Response 1 (EXOKAY) is accepted. A store (d_write_i=1) reports cause 7 on write response 2 or 3.
- R6: On the data cache port (d_tgt_i=1), a load reports cause 5 only for read response 0 with d_excl_i=1 and d_amo_i=0. A store reports cause 7 only for write response 2 or 3 with d_excl_i=1. Every other cache response is ignored and leaves exc_valid_o low.
- R7: On local memory (d_tgt_i=2 or 3) an uncorrectable flag faults, and a correctable flag faults only when CE_EXC=1. A load fault reports cause 5. A store fault reports cause 7, but only for byte or half stores; on word stores the flags are ignored. The same ECC rule applies to local fetches (cause 1).
- R8: A store (d_write_i=1) with pmp_fail_i=1 reports cause 7 regardless of target or response. pmp_fail_i is ignored on loads.
- R9: Misalignment takes precedence. A misaligned data access reports only cause 4 or 6, whatever the response, ECC or pmp_fail_i inputs are.
- R10: When both sides raise an exception in the same cycle, the data cause is reported. exc_tval_o carries the address of the access whose cause is reported.
- R11: An access presented in cycle n is reported in cycle n+1 for exactly one cycle. Back-to-back faults are reported in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| if_req_i | input | 1 | Fetch completion present |
| if_addr_i | input | 32 | Fetch address |
| if_local_i | input | 1 | Fetch served by local memory (1) or peripheral port (0) |
| if_rresp_i | input | 2 | Peripheral read response for the fetch |
| if_ue_i | input | 1 | Local-memory uncorrectable error, fetch side |
| if_ce_i | input | 1 | Local-memory correctable error, fetch side |
| d_req_i | input | 1 | Data completion present |
| d_addr_i | input | 32 | Data address |
| d_size_i | input | 2 | Access size: 0 byte, 1 half, 2/3 word |
| d_write_i | input | 1 | Write phase (store, SC, AMO write) |
| d_amo_i | input | 1 | Atomic memory operation |
| d_excl_i | input | 1 | Exclusive access (LR or SC) |
| d_tgt_i | input | 2 | Target: 0 peripheral, 1 cache, 2/3 local memory |
| d_rresp_i | input | 2 | AXI4 read response |
| d_bresp_i | input | 2 | AXI4 write response |
| d_ue_i | input | 1 | Local-memory uncorrectable error, data side |
| d_ce_i | input | 1 | Local-memory correctable error, data side |
| pmp_fail_i | input | 1 | Protection check failed for this access |
| exc_valid_o | output | 1 | Exception reported |
| exc_cause_o | output | 5 | Cause code (0,1,4,5,6,7) |
| exc_tval_o | output | 32 | Faulting address |

## Verification
Every internal decision ends up in the single output register one cycle later, so a wrong classification shows as a wrong cause or trap value at the very next edge. A flipped priority or precedence gives a cause from the wrong side (fetch instead of data, fault instead of misaligned), or a tval holding the other address, and this too appears in that one cycle. A wrongly honoured ignored response shows as a spurious exc_valid_o pulse in the cycle after the access. The table pairs each response, size and attribute combination with the cycle after it. A second instance, built with compressed fetch and correctable-error trapping enabled, covers the parameter-selected behaviour.

// File: rtl/mem_exc_pkg.sv
package mem_exc_pkg;

  typedef enum logic [4:0] {
    CAUSE_IF_MISAL = 5'd0,
    CAUSE_IF_FAULT = 5'd1,
    CAUSE_LD_MISAL = 5'd4,
    CAUSE_LD_FAULT = 5'd5,
    CAUSE_ST_MISAL = 5'd6,
    CAUSE_ST_FAULT = 5'd7
  } cause_e;

  localparam logic [1:0] RESP_OKAY   = 2'd0;
  localparam logic [1:0] RESP_EXOKAY = 2'd1;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  localparam logic [1:0] TGT_PERIPH = 2'd0;
  localparam logic [1:0] TGT_CACHE  = 2'd1;

  // error = SLVERR or DECERR
  function automatic logic resp_err(input logic [1:0] r);
    return (r != RESP_OKAY) && (r != RESP_EXOKAY);
  endfunction

endpackage

// File: rtl/mem_exc_fetch_chk.sv
module mem_exc_fetch_chk
  import mem_exc_pkg::*;
#(
  parameter bit COMPRESSED = 1'b0,
  parameter bit CE_EXC     = 1'b0
) (
  input  logic       req_i,
  input  logic       addr_b1_i,
  input  logic       local_i,
  input  logic [1:0] rresp_i,
  input  logic       ue_i,
  input  logic       ce_i,
  output logic       exc_o,
  output logic [4:0] cause_o
);

  logic misal, ecc_err, fault;

  assign misal   = !COMPRESSED && addr_b1_i;
  assign ecc_err = ue_i || (CE_EXC && ce_i);
  assign fault   = local_i ? ecc_err : resp_err(rresp_i);

  assign exc_o   = req_i && (misal || fault);
  assign cause_o = misal ? CAUSE_IF_MISAL : CAUSE_IF_FAULT;

  always_comb begin
    if (exc_o && COMPRESSED)
      a_r2_no_fetch_misal : assert (cause_o != CAUSE_IF_MISAL);
  end

endmodule

// File: rtl/mem_exc_data_chk.sv
module mem_exc_data_chk
  import mem_exc_pkg::*;
#(
  parameter bit CE_EXC = 1'b0
) (
  input  logic       req_i,
  input  logic [1:0] addr_lo_i,
  input  logic [1:0] size_i,
  input  logic       write_i,
  input  logic       amo_i,
  input  logic       excl_i,
  input  logic [1:0] tgt_i,
  input  logic [1:0] rresp_i,
  input  logic [1:0] bresp_i,
  input  logic       ue_i,
  input  logic       ce_i,
  input  logic       pmp_fail_i,
  output logic       exc_o,
  output logic [4:0] cause_o
);

  logic misal, ecc_err, sub_word, ld_flt, st_flt, fault;

  // size[1] set = word
  always_comb begin
    if (size_i[1])            misal = addr_lo_i != 2'b00;
    else if (size_i == SZ_HALF) misal = addr_lo_i[0];
    else                      misal = 1'b0;
  end

  assign ecc_err  = ue_i || (CE_EXC && ce_i);
  assign sub_word = (size_i == SZ_BYTE) || (size_i == SZ_HALF);

  always_comb begin
    ld_flt = 1'b0;
    st_flt = 1'b0;
    if (tgt_i[1]) begin
      ld_flt = ecc_err;
      st_flt = ecc_err && sub_word;
    end else if (tgt_i == TGT_CACHE) begin
      ld_flt = excl_i && !amo_i && (rresp_i == RESP_OKAY);
      st_flt = excl_i && resp_err(bresp_i);
    end else begin
      ld_flt = resp_err(rresp_i) || ((rresp_i == RESP_OKAY) && (excl_i || amo_i));
      st_flt = resp_err(bresp_i);
    end
  end

  assign fault = write_i ? (st_flt || pmp_fail_i) : ld_flt;
  assign exc_o = req_i && (misal || fault);

  always_comb begin
    if (misal)        cause_o = (write_i || amo_i) ? CAUSE_ST_MISAL : CAUSE_LD_MISAL;
    else if (write_i) cause_o = CAUSE_ST_FAULT;
    else              cause_o = CAUSE_LD_FAULT;
  end

  // R9: misaligned access never yields a fault code
  always_comb begin
    if (req_i && misal)
      a_r9_misal_first : assert (cause_o == CAUSE_LD_MISAL || cause_o == CAUSE_ST_MISAL);
  end

endmodule

// File: rtl/mem_exc_detect.sv
module mem_exc_detect
  import mem_exc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter bit COMPRESSED = 1'b0,
  parameter bit CE_EXC     = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              if_req_i,
  input  logic [ADDR_W-1:0] if_addr_i,
  input  logic              if_local_i,
  input  logic [1:0]        if_rresp_i,
  input  logic              if_ue_i,
  input  logic              if_ce_i,
  input  logic              d_req_i,
  input  logic [ADDR_W-1:0] d_addr_i,
  input  logic [1:0]        d_size_i,
  input  logic              d_write_i,
  input  logic              d_amo_i,
  input  logic              d_excl_i,
  input  logic [1:0]        d_tgt_i,
  input  logic [1:0]        d_rresp_i,
  input  logic [1:0]        d_bresp_i,
  input  logic              d_ue_i,
  input  logic              d_ce_i,
  input  logic              pmp_fail_i,
  output logic              exc_valid_o,
  output logic [4:0]        exc_cause_o,
  output logic [ADDR_W-1:0] exc_tval_o
);

  logic              f_exc, d_exc, nxt_valid;
  logic [4:0]        f_cause, d_cause, nxt_cause;
  logic [ADDR_W-1:0] nxt_tval;

  mem_exc_fetch_chk #(.COMPRESSED(COMPRESSED), .CE_EXC(CE_EXC)) u_fetch (
    .req_i     (if_req_i),
    .addr_b1_i (if_addr_i[1]),
    .local_i   (if_local_i),
    .rresp_i   (if_rresp_i),
    .ue_i      (if_ue_i),
    .ce_i      (if_ce_i),
    .exc_o     (f_exc),
    .cause_o   (f_cause)
  );

  mem_exc_data_chk #(.CE_EXC(CE_EXC)) u_data (
    .req_i      (d_req_i),
    .addr_lo_i  (d_addr_i[1:0]),
    .size_i     (d_size_i),
    .write_i    (d_write_i),
    .amo_i      (d_amo_i),
    .excl_i     (d_excl_i),
    .tgt_i      (d_tgt_i),
    .rresp_i    (d_rresp_i),
    .bresp_i    (d_bresp_i),
    .ue_i       (d_ue_i),
    .ce_i       (d_ce_i),
    .pmp_fail_i (pmp_fail_i),
    .exc_o      (d_exc),
    .cause_o    (d_cause)
  );

  // data access is the older instruction
  always_comb begin
    nxt_valid = d_exc || f_exc;
    nxt_cause = '0;
    nxt_tval  = '0;
    if (d_exc) begin
      nxt_cause = d_cause;
      nxt_tval  = d_addr_i;
    end else if (f_exc) begin
      nxt_cause = f_cause;
      nxt_tval  = if_addr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exc_valid_o <= 1'b0;
      exc_cause_o <= '0;
      exc_tval_o  <= '0;
    end else begin
      exc_valid_o <= nxt_valid;
      exc_cause_o <= nxt_cause;
      exc_tval_o  <= nxt_tval;
    end
  end

  a_r2_fetch_misal : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!COMPRESSED && if_req_i && if_addr_i[1] && !d_req_i)
    |=> (exc_valid_o && exc_cause_o == CAUSE_IF_MISAL));

  a_r4_word_ld_misal : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_req_i && d_size_i[1] && d_addr_i[1:0] != 2'b00 && !d_write_i && !d_amo_i)
    |=> (exc_valid_o && exc_cause_o == CAUSE_LD_MISAL));

  a_r6_cache_ignored : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_req_i && d_tgt_i == TGT_CACHE && !d_excl_i && !d_write_i &&
     d_size_i == SZ_BYTE && !if_req_i)
    |=> !exc_valid_o);

  a_r10_tval_data : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_req_i && d_addr_i[0] && d_size_i != SZ_BYTE)
    |=> (exc_tval_o == $past(d_addr_i)));

  a_r11_idle_quiet : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!d_req_i && !if_req_i) |=> !exc_valid_o);

endmodule

// File: tb/mem_exc_detect_bench.sv
`timescale 1ns/1ps
module mem_exc_detect_bench;

  typedef struct packed {
    logic [3:0]  tag;
    logic        if_req;
    logic [31:0] if_addr;
    logic        if_loc;
    logic [1:0]  if_resp;
    logic        if_ue;
    logic        if_ce;
    logic        d_req;
    logic [31:0] d_addr;
    logic [1:0]  d_size;
    logic        d_wr;
    logic        d_amo;
    logic        d_excl;
    logic [1:0]  d_tgt;
    logic [1:0]  d_rresp;
    logic [1:0]  d_bresp;
    logic        d_ue;
    logic        d_ce;
    logic        pmp;
    logic        ev;
    logic [4:0]  ec;
    logic [31:0] etv;
  } vec_t;

  localparam int NV = 31;
  // tag | fetch: req addr loc resp ue ce | data: req addr size wr amo excl tgt rresp bresp ue ce pmp | exp
  localparam vec_t VECS [NV] = '{
    '{2, 1,32'h102,0,0,0,0, 0,32'h0,0,0,0,0,0,0,0,0,0,0, 1,0,32'h102},   // R2 fetch bit1
    '{2, 1,32'h104,0,0,0,0, 0,32'h0,0,0,0,0,0,0,0,0,0,0, 0,0,32'h0},     // R2 aligned fetch
    '{3, 1,32'h200,0,2,0,0, 0,32'h0,0,0,0,0,0,0,0,0,0,0, 1,1,32'h200},   // R3 SLVERR
    '{3, 1,32'h204,0,3,0,0, 0,32'h0,0,0,0,0,0,0,0,0,0,0, 1,1,32'h204},   // R3 DECERR
    '{3, 1,32'h300,1,0,1,0, 0,32'h0,0,0,0,0,0,0,0,0,0,0, 1,1,32'h300},   // R3 local UE
    '{7, 1,32'h304,1,0,0,1, 0,32'h0,0,0,0,0,0,0,0,0,0,0, 0,0,32'h0},     // R7 CE ignored
    '{4, 0,32'h0,0,0,0,0, 1,32'h1001,2,0,0,0,0,0,0,0,0,0, 1,4,32'h1001}, // R4 word load
    '{4, 0,32'h0,0,0,0,0, 1,32'h1003,1,1,0,0,0,0,0,0,0,0, 1,6,32'h1003}, // R4 half store
    '{4, 0,32'h0,0,0,0,0, 1,32'h1002,2,0,1,0,0,0,0,0,0,0, 1,6,32'h1002}, // R4 amo read
    '{4, 0,32'h0,0,0,0,0, 1,32'h1003,0,0,0,0,0,0,0,0,0,0, 0,0,32'h0},    // R4 byte ok
    '{9, 0,32'h0,0,0,0,0, 1,32'h1006,2,0,0,0,0,2,0,0,0,0, 1,4,32'h1006}, // R9 over rresp
    '{9, 0,32'h0,0,0,0,0, 1,32'h1005,2,1,0,0,0,0,0,0,0,1, 1,6,32'h1005}, // R9 over pmp
    '{5, 0,32'h0,0,0,0,0, 1,32'h2000,2,0,0,0,0,2,0,0,0,0, 1,5,32'h2000}, // R5 rresp err
    '{5, 0,32'h0,0,0,0,0, 1,32'h2004,2,0,0,1,0,0,0,0,0,0, 1,5,32'h2004}, // R5 LR OKAY
    '{5, 0,32'h0,0,0,0,0, 1,32'h2008,2,0,0,1,0,1,0,0,0,0, 0,0,32'h0},    // R5 LR EXOKAY
    '{5, 0,32'h0,0,0,0,0, 1,32'h200c,2,0,1,0,0,0,0,0,0,0, 1,5,32'h200c}, // R5 AMO OKAY
    '{5, 0,32'h0,0,0,0,0, 1,32'h2010,2,0,0,0,0,0,0,0,0,0, 0,0,32'h0},    // R5 plain OKAY
    '{5, 0,32'h0,0,0,0,0, 1,32'h2014,2,1,0,0,0,0,2,0,0,0, 1,7,32'h2014}, // R5 bresp err
    '{6, 0,32'h0,0,0,0,0, 1,32'h2100,2,0,0,0,1,2,0,0,0,0, 0,0,32'h0},    // R6 plain err ignored
    '{6, 0,32'h0,0,0,0,0, 1,32'h2104,2,0,0,1,1,0,0,0,0,0, 1,5,32'h2104}, // R6 LR OKAY
    '{6, 0,32'h0,0,0,0,0, 1,32'h2108,2,0,0,1,1,1,0,0,0,0, 0,0,32'h0},    // R6 LR EXOKAY
    '{6, 0,32'h0,0,0,0,0, 1,32'h210c,2,1,0,0,1,0,3,0,0,0, 0,0,32'h0},    // R6 store ignored
    '{6, 0,32'h0,0,0,0,0, 1,32'h2110,2,1,0,1,1,0,2,0,0,0, 1,7,32'h2110}, // R6 SC err
    '{6, 0,32'h0,0,0,0,0, 1,32'h2114,2,0,1,1,1,0,0,0,0,0, 0,0,32'h0},    // R6 AMO read ignored
    '{7, 0,32'h0,0,0,0,0, 1,32'h3000,2,0,0,0,2,0,0,1,0,0, 1,5,32'h3000}, // R7 load UE
    '{7, 0,32'h0,0,0,0,0, 1,32'h3004,2,0,0,0,2,0,0,0,1,0, 0,0,32'h0},    // R7 load CE off
    '{7, 0,32'h0,0,0,0,0, 1,32'h3006,1,1,0,0,3,0,0,1,0,0, 1,7,32'h3006}, // R7 half store UE
    '{7, 0,32'h0,0,0,0,0, 1,32'h3008,2,1,0,0,2,0,0,1,0,0, 0,0,32'h0},    // R7 word store UE
    '{8, 0,32'h0,0,0,0,0, 1,32'h4000,2,1,0,0,0,0,0,0,0,1, 1,7,32'h4000}, // R8 store pmp
    '{8, 0,32'h0,0,0,0,0, 1,32'h4004,2,0,0,0,0,0,0,0,0,1, 0,0,32'h0},    // R8 load pmp
    '{10,1,32'h402,0,0,0,0, 1,32'h5000,2,0,0,0,0,2,0,0,0,0, 1,5,32'h5000} // R10 data wins
  };

  localparam int NA = 5;
  localparam vec_t ALTV [NA] = '{
    '{2, 1,32'h102,0,0,0,0, 0,32'h0,0,0,0,0,0,0,0,0,0,0, 0,0,32'h0},     // R2 compressed
    '{7, 0,32'h0,0,0,0,0, 1,32'h40,2,0,0,0,2,0,0,0,1,0, 1,5,32'h40},     // R7 load CE on
    '{7, 0,32'h0,0,0,0,0, 1,32'h44,2,1,0,0,2,0,0,0,1,0, 0,0,32'h0},      // R7 word store CE
    '{7, 0,32'h0,0,0,0,0, 1,32'h47,0,1,0,0,2,0,0,0,1,0, 1,7,32'h47},     // R7 byte store CE
    '{7, 1,32'h80,1,0,0,1, 0,32'h0,0,0,0,0,0,0,0,0,0,0, 1,1,32'h80}      // R7 fetch CE
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic if_req_i, if_local_i, if_ue_i, if_ce_i;
  logic [31:0] if_addr_i, d_addr_i;
  logic [1:0] if_rresp_i, d_size_i, d_tgt_i, d_rresp_i, d_bresp_i;
  logic d_req_i, d_write_i, d_amo_i, d_excl_i, d_ue_i, d_ce_i, pmp_fail_i;
  logic exc_valid_o, alt_valid;
  logic [4:0] exc_cause_o, alt_cause;
  logic [31:0] exc_tval_o, alt_tval;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  mem_exc_detect u_mem_exc_detect (
    .clk_i, .rst_ni, .if_req_i, .if_addr_i, .if_local_i, .if_rresp_i, .if_ue_i, .if_ce_i,
    .d_req_i, .d_addr_i, .d_size_i, .d_write_i, .d_amo_i, .d_excl_i, .d_tgt_i,
    .d_rresp_i, .d_bresp_i, .d_ue_i, .d_ce_i, .pmp_fail_i,
    .exc_valid_o, .exc_cause_o, .exc_tval_o
  );

  mem_exc_detect #(.COMPRESSED(1'b1), .CE_EXC(1'b1)) u_mem_exc_detect_alt (
    .clk_i, .rst_ni, .if_req_i, .if_addr_i, .if_local_i, .if_rresp_i, .if_ue_i, .if_ce_i,
    .d_req_i, .d_addr_i, .d_size_i, .d_write_i, .d_amo_i, .d_excl_i, .d_tgt_i,
    .d_rresp_i, .d_bresp_i, .d_ue_i, .d_ce_i, .pmp_fail_i,
    .exc_valid_o(alt_valid), .exc_cause_o(alt_cause), .exc_tval_o(alt_tval)
  );

  task automatic drive(input vec_t v);
    if_req_i = v.if_req;   if_addr_i = v.if_addr; if_local_i = v.if_loc;
    if_rresp_i = v.if_resp; if_ue_i = v.if_ue;    if_ce_i = v.if_ce;
    d_req_i = v.d_req;     d_addr_i = v.d_addr;   d_size_i = v.d_size;
    d_write_i = v.d_wr;    d_amo_i = v.d_amo;     d_excl_i = v.d_excl;
    d_tgt_i = v.d_tgt;     d_rresp_i = v.d_rresp; d_bresp_i = v.d_bresp;
    d_ue_i = v.d_ue;       d_ce_i = v.d_ce;       pmp_fail_i = v.pmp;
  endtask

  task automatic check(input int tag, input logic ev, input logic [4:0] ec,
                       input logic [31:0] etv, input logic av, input logic [4:0] ac,
                       input logic [31:0] atv);
    checks++;
    if (av !== ev || ac !== ec || atv !== etv) begin
      errors++;
      $display("FAIL R%0d actual v=%0b c=%0d tval=%h expected v=%0b c=%0d tval=%h",
               tag, av, ac, atv, ev, ec, etv);
    end
  endtask

  task automatic run(input vec_t v, input bit alt);
    drive(v);
    @(negedge clk_i);
    if (alt) check(v.tag, v.ev, v.ec, v.etv, alt_valid, alt_cause, alt_tval);
    else     check(v.tag, v.ev, v.ec, v.etv, exc_valid_o, exc_cause_o, exc_tval_o);
  endtask

  initial begin
    drive('0);
    // R1: faulting input during reset leaves outputs clear
    drive(VECS[2]);
    repeat (3) @(negedge clk_i);
    check(1, 0, 0, 0, exc_valid_o, exc_cause_o, exc_tval_o);
    drive('0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(1, 0, 0, 0, exc_valid_o, exc_cause_o, exc_tval_o);

    for (int i = 0; i < NV; i++) run(VECS[i], 1'b0);
    for (int i = 0; i < NA; i++) run(ALTV[i], 1'b1);

    // R11: one-cycle pulse, then quiet; back-to-back distinct causes
    run(VECS[6], 1'b0);
    drive('0);
    @(negedge clk_i);
    check(11, 0, 0, 0, exc_valid_o, exc_cause_o, exc_tval_o);
    run(VECS[2], 1'b0);
    run(VECS[22], 1'b0);
    drive('0);
    @(negedge clk_i);
    check(11, 0, 0, 0, exc_valid_o, exc_cause_o, exc_tval_o);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule